// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a programmable down-counter that produces a local interrupt request. Software loads a starting count, picks a clock divide ratio with a 4-bit code, and sets up a timer vector entry holding the interrupt vector, a mask bit and a one-shot/periodic selection. The counter steps down once every divide-ratio bus clocks. When it expires it adds one to a pending count and, in periodic mode, reloads itself from the starting count.

While the pending count is nonzero and the entry is unmasked, the block raises a request carrying the programmed vector. The consumer acknowledges each delivery, and each acknowledge removes one pending expiry. A global software enable gates the block: turning it off masks the entry and discards pending expiries. Registers are written through one write port. A combinational read port returns the register selected by its own select input.

Top module: `lict_timer`

## Requirements
- R1: The divide ratio is 2^e, where e = ({div[3], div[1:0]} + 1) mod 8. Code 4'b1011 divides by 1, 4'b0000 by 2 and 4'b1010 by 128.
- R2: Writing the initial-count register (select 1) loads the current count with the written value in the next cycle, restarts the divider and clears the pending count, even while a countdown is running.
- R3: An initial count of zero leaves the timer stopped, and the current count (select 2) reads zero.
- R4: A running current count decreases by one every ratio clocks. A count loaded with N expires N*ratio clocks after the load, and the current count never wraps below zero.
- R5: On expiry the current count reloads from the initial count when the periodic bit (bit 9 of the vector entry) is set, and goes to zero and stays there when it is clear.
- R6: intr_req is high exactly while the pending count is nonzero and the mask bit (bit 8 of the vector entry) is clear. intr_vector carries vector-entry bits [7:0]. intr_ack while intr_req is high removes one pending expiry.
- R7: Writing the control register (select 4) with bit 0 clear forces the mask bit to 1 and zeroes the pending count.
- R8: After reset the divide code, initial count, current count, pending count, vector, periodic bit and enable all read zero, and the mask bit reads one.
- R9: A new divide code takes effect at the next periodic reload or restart, not in the middle of a count.
- R10: The pending count saturates at 2^PEND_W-1 and does not wrap.
- R11: A vector-entry write while the enable bit is clear stores the vector and periodic bit but leaves the mask bit set.
- R12: The read port returns the divide code (select 0), the initial count (select 1), the current count (select 2), the vector entry (select 3) and the enable bit (select 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 3 | Register select for the read |
| rd_data | output | DATA_W | Read data of the selected register |
| intr_req | output | 1 | Timer interrupt request |
| intr_vector | output | VEC_W | Vector carried with the request |
| intr_ack | input | 1 | Delivery acknowledge, one pending expiry per cycle |
| pend_count | output | PEND_W | Expiries not yet delivered |

## Verification
The assertions assume that wr_sel uses only the five defined codes and that a write of the initial count is never combined with another register write in the same cycle, since the block has a single write port. They also assume that an acknowledge is meaningful only while a request is raised. The stimulus drives only defined selects, issues one write per cycle, and applies acknowledges either as single pulses while a request is visible or as a held level that the block qualifies with its own request. A behavioural reference model follows the count, the pending total and the request every clock, through restarts, divide changes in mid-count, masking and saturation.

// File: rtl/lict_pkg.sv
package lict_pkg;
   typedef enum logic [2:0] {
      SEL_DIV  = 3'd0,
      SEL_INIT = 3'd1,
      SEL_CUR  = 3'd2,
      SEL_LVT  = 3'd3,
      SEL_CTRL = 3'd4
   } lict_sel_e;

   localparam int unsigned LICT_MAX_EXP = 7;

   // exponent of the power-of-two divide ratio from the scattered 4-bit code
   function automatic logic [2:0] lict_div_exp(input logic [3:0] code);
      return {code[3], code[1:0]} + 3'd1;
   endfunction
endpackage

// File: rtl/lict_prescale.sv
module lict_prescale #(
   parameter int unsigned PS_W = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       relatch,
   input  logic [3:0] div_code,
   input  logic       run,
   output logic       tick
);
   import lict_pkg::*;

   if (PS_W < LICT_MAX_EXP) begin : g_bad_width
      $error("lict_prescale: PS_W too small for the largest divide ratio");
   end

   logic [PS_W-1:0] lim_q, cnt_q, lim_nx;

   always_comb begin
      lim_nx = PS_W'((32'd1 << lict_div_exp(div_code)) - 32'd1);
   end

   assign tick = run && (cnt_q == lim_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lim_q <= '0;
         cnt_q <= '0;
      end else if (relatch) begin
         lim_q <= lim_nx;
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= (cnt_q == lim_q) ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/lict_down.sv
module lict_down #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             periodic,
   input  logic             tick,
   output logic [CNT_W-1:0] cur,
   output logic             running,
   output logic             expire
);
   logic [CNT_W-1:0] cur_q;

   assign cur     = cur_q;
   assign running = (cur_q != '0);
   assign expire  = tick && (cur_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q <= '0;
      end else if (restart) begin
         cur_q <= load_val;
      end else if (tick) begin
         if (expire) cur_q <= periodic ? reload_val : '0;
         else        cur_q <= cur_q - 1'b1;
      end
   end
endmodule

// File: rtl/lict_pending.sv
module lict_pending #(
   parameter int unsigned PEND_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              inc,
   input  logic              dec,
   output logic [PEND_W-1:0] cnt
);
   localparam logic [PEND_W-1:0] CNT_MAX = '1;

   if (PEND_W < 1) begin : g_bad_width
      $error("lict_pending: PEND_W must be at least 1");
   end

   logic [PEND_W-1:0] cnt_q;
   assign cnt = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt_q <= '0;
      end else begin
         unique case ({inc, dec})
            2'b10:   if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            2'b01:   if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/lict_timer.sv
module lict_timer #(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned PEND_W = 4,
   parameter int unsigned VEC_W  = 8,
   parameter int unsigned PS_W   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [2:0]        rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic              intr_req,
   output logic [VEC_W-1:0]  intr_vector,
   input  logic              intr_ack,
   output logic [PEND_W-1:0] pend_count
);
   import lict_pkg::*;

   localparam int unsigned MASK_BIT = VEC_W;
   localparam int unsigned PER_BIT  = VEC_W + 1;

   if (DATA_W < CNT_W) begin : g_bad_cnt
      $error("lict_timer: DATA_W must hold the count");
   end
   if (DATA_W < VEC_W + 2) begin : g_bad_vec
      $error("lict_timer: DATA_W must hold the vector entry");
   end

   logic [3:0]       div_q;
   logic [CNT_W-1:0] init_q;
   logic [VEC_W-1:0] vec_q;
   logic             mask_q, per_q, en_q;

   logic             wr_init, wr_div, wr_lvt, wr_ctrl, ctrl_off;
   logic [CNT_W-1:0] cur_q;
   logic [PEND_W-1:0] pend_q;
   logic             running, tick, expire, deliver;

   assign wr_init  = wr_en && (wr_sel == SEL_INIT);
   assign wr_div   = wr_en && (wr_sel == SEL_DIV);
   assign wr_lvt   = wr_en && (wr_sel == SEL_LVT);
   assign wr_ctrl  = wr_en && (wr_sel == SEL_CTRL);
   assign ctrl_off = wr_ctrl && !wr_data[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q  <= '0;
         init_q <= '0;
         vec_q  <= '0;
         mask_q <= 1'b1;
         per_q  <= 1'b0;
         en_q   <= 1'b0;
      end else begin
         if (wr_div)  div_q  <= wr_data[3:0];
         if (wr_init) init_q <= wr_data[CNT_W-1:0];
         if (wr_lvt) begin
            vec_q  <= wr_data[VEC_W-1:0];
            per_q  <= wr_data[PER_BIT];
            mask_q <= wr_data[MASK_BIT] || !en_q;
         end
         if (wr_ctrl) en_q <= wr_data[0];
         if (ctrl_off) mask_q <= 1'b1;
      end
   end

   lict_prescale #(.PS_W(PS_W)) i_prescale (
      .clk      (clk),
      .rst_n    (rst_n),
      .relatch  (wr_init || expire),
      .div_code (div_q),
      .run      (running),
      .tick     (tick)
   );

   lict_down #(.CNT_W(CNT_W)) i_down (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (wr_init),
      .load_val   (wr_data[CNT_W-1:0]),
      .reload_val (init_q),
      .periodic   (per_q),
      .tick       (tick),
      .cur        (cur_q),
      .running    (running),
      .expire     (expire)
   );

   assign intr_req    = (pend_q != '0) && !mask_q;
   assign intr_vector = vec_q;
   assign deliver     = intr_req && intr_ack;
   assign pend_count  = pend_q;

   lict_pending #(.PEND_W(PEND_W)) i_pending (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (wr_init || ctrl_off),
      .inc   (expire),
      .dec   (deliver),
      .cnt   (pend_q)
   );

   always_comb begin
      rd_data = '0;
      unique case (rd_sel)
         SEL_DIV:  rd_data[3:0]       = div_q;
         SEL_INIT: rd_data[CNT_W-1:0] = init_q;
         SEL_CUR:  rd_data[CNT_W-1:0] = cur_q;
         SEL_LVT: begin
            rd_data[VEC_W-1:0] = vec_q;
            rd_data[MASK_BIT]  = mask_q;
            rd_data[PER_BIT]   = per_q;
         end
         SEL_CTRL: rd_data[0] = en_q;
         default:  rd_data = '0;
      endcase
   end
endmodule

// File: rtl/lict_timer_chk.sv
module lict_timer_chk #(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned PEND_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [2:0]        wr_sel,
   input logic [DATA_W-1:0] wr_data,
   input logic              intr_ack,
   input logic [CNT_W-1:0]  cur,
   input logic [CNT_W-1:0]  init,
   input logic              mask,
   input logic [PEND_W-1:0] pend,
   input logic              intr_req
);
   localparam logic [PEND_W-1:0] PMAX = '1;

   logic ld, off;
   assign ld  = wr_en && (wr_sel == 3'd1);
   assign off = wr_en && (wr_sel == 3'd4) && !wr_data[0];

   a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (cur == $past(wr_data[CNT_W-1:0])) && (pend == '0));

   a_r3_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && wr_data[CNT_W-1:0] == '0) |=> (cur == '0));

   a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && cur != '0) |=>
         (cur == $past(cur)) || (cur == $past(cur) - 1'b1) || (cur == init));

   a_r5_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && cur == '0) |=> (cur == '0));

   a_r6_ack_drains: assert property (@(posedge clk) disable iff (!rst_n)
      (intr_req && intr_ack && !ld && !off) |=> (pend <= $past(pend)));

   a_r7_disable: assert property (@(posedge clk) disable iff (!rst_n)
      off |=> mask && (pend == '0) && !intr_req);

   a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == PMAX && !intr_ack && !ld && !off) |=> (pend == PMAX));
endmodule

bind lict_timer lict_timer_chk #(
   .CNT_W (CNT_W),
   .DATA_W(DATA_W),
   .PEND_W(PEND_W)
) i_lict_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .wr_data  (wr_data),
   .intr_ack (intr_ack),
   .cur      (cur_q),
   .init     (init_q),
   .mask     (mask_q),
   .pend     (pend_q),
   .intr_req (intr_req)
);

// File: tb/test_lict_timer.sv
module test_lict_timer;
   localparam int CNT_W = 32, DATA_W = 32, PEND_W = 4, VEC_W = 8;
   localparam int PMAX = (1 << PEND_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [2:0]        wr_sel = 3'd0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [2:0]        rd_sel = 3'd2;
   logic [DATA_W-1:0] rd_data;
   logic              intr_req;
   logic [VEC_W-1:0]  intr_vector;
   logic              intr_ack = 1'b0;
   logic [PEND_W-1:0] pend_count;

   always #10 clk = ~clk;

   lict_timer i_lict_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .intr_req(intr_req), .intr_vector(intr_vector),
      .intr_ack(intr_ack), .pend_count(pend_count)
   );

   int total = 0, bad = 0, cyc = 0;
   bit done = 0;
   string phase = "R8";

   // behavioural reference state
   int m_div, m_init, m_cur, m_pc, m_lim, m_pend, m_vec, m_en;
   bit m_mask, m_per;

   function automatic int ratio_of(int code);
      int e;
      e = ((((code >> 3) & 1) << 2) | (code & 3)) + 1;
      return 1 << (e % 8);
   endfunction

   task automatic check(string tag, longint act, longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s (phase %s): actual=%0d expected=%0d", tag, phase, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_div = 0; m_init = 0; m_cur = 0; m_pc = 0; m_lim = 0;
         m_pend = 0; m_vec = 0; m_en = 0; m_mask = 1; m_per = 0;
      end else begin
         bit req, dec, fired;
         req = (m_pend != 0) && !m_mask;
         dec = req && intr_ack;
         fired = 0;
         if (wr_en && wr_sel == 3'd1) begin
            m_init = int'(wr_data); m_cur = int'(wr_data);
            m_pc = 0; m_lim = ratio_of(m_div) - 1; m_pend = 0;
         end else begin
            if (m_cur != 0) begin
               if (m_pc == m_lim) begin
                  m_pc = 0;
                  if (m_cur == 1) begin
                     fired = 1;
                     m_lim = ratio_of(m_div) - 1;
                     m_cur = m_per ? m_init : 0;
                  end else m_cur--;
               end else m_pc++;
            end
            m_pend = m_pend + int'(fired) - int'(dec);
            if (m_pend > PMAX) m_pend = PMAX;
         end
         if (wr_en && wr_sel == 3'd0) m_div = int'(wr_data[3:0]);
         if (wr_en && wr_sel == 3'd3) begin
            m_vec = int'(wr_data[7:0]); m_per = wr_data[9];
            m_mask = wr_data[8] || (m_en == 0);
         end
         if (wr_en && wr_sel == 3'd4) begin
            m_en = int'(wr_data[0]);
            if (!wr_data[0]) begin m_mask = 1; m_pend = 0; end
         end
      end
      #5;
      if (rst_n && !done) begin
         check("R4 current count", rd_data, m_cur);
         check("R6 pending count", pend_count, m_pend);
         check("R6 request", intr_req, (m_pend != 0) && !m_mask);
         if (intr_req) check("R6 vector", intr_vector, m_vec);
      end
   end

   always @(posedge clk) begin
      if (cyc > 150000 && !done) begin
         done = 1; total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic wr(input logic [2:0] sel, input logic [DATA_W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(string tag, input logic [2:0] sel, input longint exp);
      rd_sel = sel;
      #1;
      check(tag, rd_data, exp);
      rd_sel = 3'd2;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ack_pulse();
      @(negedge clk);
      intr_ack = 1'b1;
      @(negedge clk);
      intr_ack = 1'b0;
   endtask

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);
      // R8 reset state, R12 read map
      rd_chk("R8 divide", 3'd0, 0);
      rd_chk("R8 initial", 3'd1, 0);
      rd_chk("R8 current", 3'd2, 0);
      rd_chk("R8 vector entry mask only", 3'd3, 32'h100);
      rd_chk("R8 enable", 3'd4, 0);
      check("R8 pending", pend_count, 0);
      check("R8 request", intr_req, 0);

      phase = "R1";
      wr(3'd4, 1);
      wr(3'd3, 32'h031);
      wr(3'd0, 32'hB);
      wr(3'd1, 5);
      wait_cyc(8);
      check("R1 one-shot expiry at divide-by-1", intr_req, 1);
      check("R6 vector", intr_vector, 8'h31);
      ack_pulse();
      check("R6 ack drains pending", pend_count, 0);
      check("R5 one-shot stopped", rd_data, 0);

      wr(3'd0, 32'hA);
      wr(3'd1, 2);
      wait_cyc(130);
      check("R1 divide-by-128 count", rd_data, 1);
      wait_cyc(130);

      phase = "R5";
      intr_ack = 1'b1;
      wr(3'd0, 32'h0);
      wr(3'd3, 32'h231);
      wr(3'd1, 3);
      wait_cyc(40);
      check("R5 periodic still counting", rd_data != 0, 1);

      phase = "R9";
      wr(3'd0, 32'hB);
      wait_cyc(30);
      intr_ack = 1'b0;

      phase = "R6";
      wr(3'd3, 32'h331);
      wait_cyc(20);
      check("R6 masked holds request low", intr_req, 0);
      check("R6 pending grows while masked", pend_count != 0, 1);
      wr(3'd3, 32'h231);
      check("R6 unmask raises request", intr_req, 1);

      phase = "R10";
      wr(3'd3, 32'h331);
      wr(3'd1, 1);
      wait_cyc(40);
      check("R10 pending saturated", pend_count, PMAX);

      phase = "R7";
      wr(3'd4, 0);
      check("R7 pending zeroed", pend_count, 0);
      rd_chk("R7 mask forced", 3'd3, 32'h331);

      phase = "R11";
      wr(3'd3, 32'h031);
      rd_chk("R11 mask kept while disabled", 3'd3, 32'h131);

      phase = "R2";
      wr(3'd4, 1);
      wr(3'd3, 32'h231);
      wr(3'd0, 32'h0);
      wr(3'd1, 4);
      wait_cyc(3);
      wr(3'd1, 6);
      check("R2 restart value", rd_data, 6);
      check("R2 pending cleared", pend_count, 0);
      intr_ack = 1'b1;
      wait_cyc(20);
      intr_ack = 1'b0;

      phase = "R3";
      wr(3'd1, 0);
      check("R3 zero count", rd_data, 0);
      wait_cyc(10);
      check("R3 still stopped", rd_data, 0);
      check("R3 no expiry", pend_count, 0);

      phase = "R12";
      wr(3'd0, 32'h9);
      rd_chk("R12 divide readback", 3'd0, 9);
      rd_chk("R12 initial readback", 3'd1, 0);
      rd_chk("R12 enable readback", 3'd4, 1);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule